// File: doc/BRIEF.md
# Poison-Tracking Register File for Speculative Execution

This block is a general-purpose register file in which every entry carries one extra poison flag. Code that the compiler has hoisted above a branch runs as a speculative instruction. When such an instruction hits an exception that would end the program, it poisons its destination register rather than trapping. The fault is only reported later. That happens when a non-speculative instruction consumes the poisoned value, or when a check instruction left at the original program position tests the register and asks for recovery code to run.

The pipeline drives two combinational read ports and one write port. The write port carries a speculative flag, a two-bit exception code and a flag saying that one of the instruction's sources was poisoned. Three registered outputs leave the block one cycle after the event that caused them: a poisoned-use fault, an immediate trap for write-side exceptions, and a recovery request from the check port. Register zero always reads as zero and is never poisoned.

Top module: `nat_regfile`

## Requirements
- R1: After reset every register reads data 0 with the poison flag clear, and the fault, trap and recover outputs are low.
- R2: A write with exception code 00 (none) and no poisoned source stores its data and clears the poison flag of the destination.
- R3: A speculative write with exception code 10 or 11 (fatal) sets the destination's poison flag, sets its data to 0 and raises no trap.
- R4: A non-speculative write with a fatal exception code leaves the register file unchanged, and in the next cycle raises `trap_o` with `trap_fatal_o`=1 and `trap_reg_o` equal to the destination.
- R5: A write with exception code 01 (resumable) leaves the register file unchanged, whether or not it is speculative. In the next cycle it raises `trap_o` with `trap_fatal_o`=0.
- R6: When an enabled read port sees a poisoned register and `rd_spec_i`=0, the next cycle shows `use_fault_o`=1 with that port's index and register number.
- R7: Reads with `rd_spec_i`=1 never raise `use_fault_o`, even when the register they read is poisoned.
- R8: A speculative write with exception code none and `wr_src_nat_i`=1 poisons the destination (data 0) and raises no trap.
- R9: A non-speculative write with exception code none and `wr_src_nat_i`=1 leaves the register file unchanged.
- R10: Register 0 always reads data 0 with the poison flag clear. Writes to it change nothing.
- R11: When several read ports raise a fault in the same cycle, only one fault is reported, and it carries the lowest such port index and that port's register.
- R12: A check of a poisoned register raises `recover_o` with `recover_reg_o` equal to that register in the next cycle. A check of a clean register does not raise `recover_o`.
- R13: The read ports show the register state from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_i | input | NRD | Per-port read enable (qualifies fault detection) |
| rd_addr_i | input | NRD*AW | Per-port register number, port p at bits p*AW |
| rd_spec_i | input | 1 | The reading instruction is speculative |
| rd_data_o | output | NRD*XLEN | Per-port read data |
| rd_nat_o | output | NRD | Per-port poison flag of the addressed register |
| wr_en_i | input | 1 | Write request valid |
| wr_addr_i | input | AW | Destination register |
| wr_data_i | input | XLEN | Write data |
| wr_spec_i | input | 1 | Writing instruction is speculative |
| wr_exc_i | input | 2 | Exception code: 00 none, 01 resumable, 1x fatal |
| wr_src_nat_i | input | 1 | A source of the writing instruction was poisoned |
| chk_en_i | input | 1 | Check instruction valid |
| chk_addr_i | input | AW | Register tested by the check |
| use_fault_o | output | 1 | Poisoned value consumed non-speculatively |
| use_fault_port_o | output | PW | Read port that saw the poison |
| use_fault_reg_o | output | AW | Register that was poisoned |
| trap_o | output | 1 | Write-side exception to be serviced now |
| trap_fatal_o | output | 1 | 1 = fatal, 0 = resumable |
| trap_reg_o | output | AW | Destination of the trapping write |
| recover_o | output | 1 | Recovery code must run |
| recover_reg_o | output | AW | Register whose check failed |

## Verification
The bench builds the block with 8 registers of 16 bits and two read ports. With so few registers, random traffic keeps hitting the same poisoned entries. Both ports then often address poisoned registers in the same cycle, and a write often lands on the register being read or checked. This exercises the port-priority rule and the read-before-write ordering much more often than a 32-entry file would. The two-port build also keeps the port-index output at one bit, so every value it can take is observed.

// File: rtl/nat_rf_pkg.sv
package nat_rf_pkg;

    localparam logic [1:0] EXC_NONE   = 2'b00;
    localparam logic [1:0] EXC_RESUME = 2'b01;

    typedef enum logic [1:0] {
        ACT_STORE  = 2'd0,
        ACT_POISON = 2'd1,
        ACT_DROP   = 2'd2
    } wr_act_e;

    typedef struct packed {
        logic vld;
        logic fatal;
    } trap_t;

    // Decide what a write request does to its destination entry.
    function automatic wr_act_e classify(input logic spec, input logic [1:0] exc,
                                         input logic src_nat);
        if (exc == EXC_RESUME) return ACT_DROP;
        if (exc[1])            return spec ? ACT_POISON : ACT_DROP;
        if (src_nat)           return spec ? ACT_POISON : ACT_DROP;
        return ACT_STORE;
    endfunction

    // Decide whether a write request must be serviced immediately.
    function automatic trap_t trap_of(input logic en, input logic spec, input logic [1:0] exc);
        trap_t t;
        t.vld   = en && ((exc == EXC_RESUME) || (exc[1] && !spec));
        t.fatal = exc[1];
        return t;
    endfunction

endpackage

// File: rtl/nat_rf_store.sv
module nat_rf_store
    import nat_rf_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int XLEN  = 32,
    parameter int AW    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [XLEN-1:0]             wr_data,
    input  wr_act_e                     wr_act,
    output logic [NREGS-1:0][XLEN-1:0]  data_o,
    output logic [NREGS-1:0]            nat_o
);

    logic [XLEN-1:0] data_q [NREGS];
    logic            nat_q  [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                data_q[i] <= '0;
                nat_q[i]  <= 1'b0;
            end
        end else if (wr_en && wr_addr != '0) begin
            for (int i = 1; i < NREGS; i++) begin
                if (wr_addr == AW'(i)) begin
                    case (wr_act)
                        ACT_STORE: begin
                            data_q[i] <= wr_data;
                            nat_q[i]  <= 1'b0;
                        end
                        ACT_POISON: begin
                            data_q[i] <= '0;
                            nat_q[i]  <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            data_o[i] = data_q[i];
            nat_o[i]  = nat_q[i];
        end
    end

    a_r2_store_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_act == ACT_STORE && wr_addr != '0)
        |=> (data_o[$past(wr_addr)] == $past(wr_data)) && !nat_o[$past(wr_addr)]);

    a_r3_poison_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_act == ACT_POISON && wr_addr != '0)
        |=> nat_o[$past(wr_addr)] && (data_o[$past(wr_addr)] == '0));

    a_r9_drop_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_act == ACT_DROP) |=> ($stable(data_o) && $stable(nat_o)));

    a_r10_zero_clean: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0) |=> (!nat_o[0] && data_o[0] == '0));

endmodule

// File: rtl/nat_rf_rdport.sv
module nat_rf_rdport #(
    parameter int NREGS = 16,
    parameter int XLEN  = 32,
    parameter int AW    = 4
) (
    input  logic [NREGS-1:0][XLEN-1:0] data_i,
    input  logic [NREGS-1:0]           nat_i,
    input  logic [AW-1:0]              addr_i,
    output logic [XLEN-1:0]            data_o,
    output logic                       nat_o
);

    always_comb begin
        data_o = '0;
        nat_o  = 1'b0;
        for (int i = 0; i < NREGS; i++) begin
            if (addr_i == AW'(i)) begin
                data_o = data_i[i];
                nat_o  = nat_i[i];
            end
        end
    end

endmodule

// File: rtl/nat_rf_fault_sel.sv
module nat_rf_fault_sel #(
    parameter int NRD = 2,
    parameter int AW  = 4,
    parameter int PW  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NRD-1:0]    hit_i,
    input  logic [NRD*AW-1:0] addr_i,
    output logic              vld_o,
    output logic [PW-1:0]     port_o,
    output logic [AW-1:0]     reg_o
);

    logic [PW-1:0] sel;
    logic [AW-1:0] sel_reg;

    // Lowest index wins: scan from the top down so the last match is the smallest.
    always_comb begin
        sel     = '0;
        sel_reg = '0;
        for (int p = NRD - 1; p >= 0; p--) begin
            if (hit_i[p]) begin
                sel     = PW'(p);
                sel_reg = addr_i[p*AW +: AW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            port_o <= '0;
            reg_o  <= '0;
        end else begin
            vld_o  <= |hit_i;
            port_o <= sel;
            reg_o  <= sel_reg;
        end
    end

    a_r11_low_port: assert property (@(posedge clk) disable iff (rst)
        hit_i[0] |=> (vld_o && port_o == '0 && reg_o == $past(addr_i[AW-1:0])));

endmodule

// File: rtl/nat_regfile.sv
module nat_regfile
    import nat_rf_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int XLEN  = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(NREGS),
    localparam int PW   = (NRD > 1) ? $clog2(NRD) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NRD-1:0]       rd_en_i,
    input  logic [NRD*AW-1:0]    rd_addr_i,
    input  logic                 rd_spec_i,
    output logic [NRD*XLEN-1:0]  rd_data_o,
    output logic [NRD-1:0]       rd_nat_o,
    input  logic                 wr_en_i,
    input  logic [AW-1:0]        wr_addr_i,
    input  logic [XLEN-1:0]      wr_data_i,
    input  logic                 wr_spec_i,
    input  logic [1:0]           wr_exc_i,
    input  logic                 wr_src_nat_i,
    input  logic                 chk_en_i,
    input  logic [AW-1:0]        chk_addr_i,
    output logic                 use_fault_o,
    output logic [PW-1:0]        use_fault_port_o,
    output logic [AW-1:0]        use_fault_reg_o,
    output logic                 trap_o,
    output logic                 trap_fatal_o,
    output logic [AW-1:0]        trap_reg_o,
    output logic                 recover_o,
    output logic [AW-1:0]        recover_reg_o
);

    logic [NREGS-1:0][XLEN-1:0] ent_data;
    logic [NREGS-1:0]           ent_nat;
    wr_act_e                    act;
    trap_t                      trap_d;
    logic [NRD-1:0]             hit;
    logic [XLEN-1:0]            chk_data_unused;
    logic                       chk_nat;

    assign act    = classify(wr_spec_i, wr_exc_i, wr_src_nat_i);
    assign trap_d = trap_of(wr_en_i, wr_spec_i, wr_exc_i);

    nat_rf_store #(.NREGS(NREGS), .XLEN(XLEN), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .wr_act  (act),
        .data_o  (ent_data),
        .nat_o   (ent_nat)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        nat_rf_rdport #(.NREGS(NREGS), .XLEN(XLEN), .AW(AW)) u_rd (
            .data_i (ent_data),
            .nat_i  (ent_nat),
            .addr_i (rd_addr_i[p*AW +: AW]),
            .data_o (rd_data_o[p*XLEN +: XLEN]),
            .nat_o  (rd_nat_o[p])
        );
        assign hit[p] = rd_en_i[p] && !rd_spec_i && rd_nat_o[p];
    end

    nat_rf_rdport #(.NREGS(NREGS), .XLEN(XLEN), .AW(AW)) u_chk (
        .data_i (ent_data),
        .nat_i  (ent_nat),
        .addr_i (chk_addr_i),
        .data_o (chk_data_unused),
        .nat_o  (chk_nat)
    );

    nat_rf_fault_sel #(.NRD(NRD), .AW(AW), .PW(PW)) u_fault (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (hit),
        .addr_i (rd_addr_i),
        .vld_o  (use_fault_o),
        .port_o (use_fault_port_o),
        .reg_o  (use_fault_reg_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_o        <= 1'b0;
            trap_fatal_o  <= 1'b0;
            trap_reg_o    <= '0;
            recover_o     <= 1'b0;
            recover_reg_o <= '0;
        end else begin
            trap_o        <= trap_d.vld;
            trap_fatal_o  <= trap_d.vld && trap_d.fatal;
            trap_reg_o    <= trap_d.vld ? wr_addr_i : '0;
            recover_o     <= chk_en_i && chk_nat;
            recover_reg_o <= (chk_en_i && chk_nat) ? chk_addr_i : '0;
        end
    end

    a_r4_fatal_trap: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_exc_i[1] && !wr_spec_i) |=> (trap_o && trap_fatal_o));

    a_r5_resume_trap: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_exc_i == EXC_RESUME) |=> (trap_o && !trap_fatal_o));

    a_r6_use_fault: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i[0] && !rd_spec_i && rd_nat_o[0]) |=> use_fault_o);

    a_r7_spec_silent: assert property (@(posedge clk) disable iff (rst)
        rd_spec_i |=> !use_fault_o);

    a_r12_recover_cause: assert property (@(posedge clk) disable iff (rst)
        recover_o |-> ($past(chk_en_i) && $past(chk_addr_i) == recover_reg_o));

endmodule

// File: tb/sim_nat_regfile.sv
`timescale 1ns/1ps
module sim_nat_regfile;

    localparam int NREGS = 8;
    localparam int XLEN  = 16;
    localparam int NRD   = 2;
    localparam int AW    = 3;
    localparam int PW    = 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NRD-1:0]      rd_en = '0;
    logic [NRD*AW-1:0]   rd_addr = '0;
    logic                rd_spec = 1'b0;
    logic [NRD*XLEN-1:0] rd_data;
    logic [NRD-1:0]      rd_nat;
    logic                wr_en = 1'b0;
    logic [AW-1:0]       wr_addr = '0;
    logic [XLEN-1:0]     wr_data = '0;
    logic                wr_spec = 1'b0;
    logic [1:0]          wr_exc = 2'b00;
    logic                wr_src = 1'b0;
    logic                chk_en = 1'b0;
    logic [AW-1:0]       chk_addr = '0;
    logic                uf;
    logic [PW-1:0]       uf_port;
    logic [AW-1:0]       uf_reg;
    logic                trap, trap_fatal;
    logic [AW-1:0]       trap_reg;
    logic                rec;
    logic [AW-1:0]       rec_reg;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural reference model
    int m_data [NREGS];
    bit m_nat  [NREGS];
    int e_uf, e_ufp, e_ufr, e_tr, e_tf, e_trg, e_rec, e_recr;

    always #2 clk = ~clk;

    nat_regfile #(.NREGS(NREGS), .XLEN(XLEN), .NRD(NRD)) u0 (
        .clk(clk), .rst(rst),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_spec_i(rd_spec),
        .rd_data_o(rd_data), .rd_nat_o(rd_nat),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .wr_spec_i(wr_spec), .wr_exc_i(wr_exc), .wr_src_nat_i(wr_src),
        .chk_en_i(chk_en), .chk_addr_i(chk_addr),
        .use_fault_o(uf), .use_fault_port_o(uf_port), .use_fault_reg_o(uf_reg),
        .trap_o(trap), .trap_fatal_o(trap_fatal), .trap_reg_o(trap_reg),
        .recover_o(rec), .recover_reg_o(rec_reg)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit we, input int wa, input int wd, input bit ws,
                         input int wx, input bit wsrc, input int ra0, input int ra1,
                         input int ren, input bit rs, input bit ce, input int ca);
        wr_en = we; wr_addr = AW'(wa); wr_data = XLEN'(wd); wr_spec = ws;
        wr_exc = 2'(wx); wr_src = wsrc;
        rd_addr = {AW'(ra1), AW'(ra0)}; rd_en = 2'(ren); rd_spec = rs;
        chk_en = ce; chk_addr = AW'(ca);
    endtask

    // One clock: compare reads before the edge, step the model, compare registered outputs after.
    task automatic cycle();
        int a;
        int wa;
        #1;
        for (int p = 0; p < NRD; p++) begin
            a = int'(rd_addr[p*AW +: AW]);
            chk("R2/R13 read data", int'(rd_data[p*XLEN +: XLEN]), m_data[a]);
            chk("R3/R8 read poison", int'(rd_nat[p]), int'(m_nat[a]));
        end
        e_uf = 0; e_ufp = 0; e_ufr = 0;
        for (int p = NRD - 1; p >= 0; p--) begin
            a = int'(rd_addr[p*AW +: AW]);
            if (rd_en[p] && !rd_spec && m_nat[a]) begin
                e_uf = 1; e_ufp = p; e_ufr = a;
            end
        end
        e_rec  = (chk_en && m_nat[int'(chk_addr)]) ? 1 : 0;
        e_recr = e_rec ? int'(chk_addr) : 0;
        wa = int'(wr_addr);
        e_tr = 0; e_tf = 0; e_trg = 0;
        if (wr_en) begin
            if (wr_exc == 2'b01) begin
                e_tr = 1; e_trg = wa;
            end else if (wr_exc[1]) begin
                if (wr_spec) begin
                    if (wa != 0) begin m_data[wa] = 0; m_nat[wa] = 1; end
                end else begin
                    e_tr = 1; e_tf = 1; e_trg = wa;
                end
            end else if (wr_src) begin
                if (wr_spec && wa != 0) begin m_data[wa] = 0; m_nat[wa] = 1; end
            end else if (wa != 0) begin
                m_data[wa] = int'(wr_data); m_nat[wa] = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R6/R11 fault valid", int'(uf), e_uf);
        if (e_uf != 0) begin
            chk("R11 fault port", int'(uf_port), e_ufp);
            chk("R6 fault reg", int'(uf_reg), e_ufr);
        end
        chk("R4/R5 trap", int'(trap), e_tr);
        if (e_tr != 0) begin
            chk("R4/R5 trap kind", int'(trap_fatal), e_tf);
            chk("R4 trap reg", int'(trap_reg), e_trg);
        end
        chk("R12 recover", int'(rec), e_rec);
        if (e_rec != 0) chk("R12 recover reg", int'(rec_reg), e_recr);
    endtask

    task automatic look(input int a, input int exp_d, input int exp_n, input string req);
        drive(0, 0, 0, 0, 0, 0, a, a, 0, 0, 0, 0);
        #1;
        chk(req, int'(rd_data[XLEN-1:0]), exp_d);
        chk(req, int'(rd_nat[0]), exp_n);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) begin m_data[i] = 0; m_nat[i] = 0; end
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state of all entries and outputs
        chk("R1 fault low", int'(uf), 0);
        chk("R1 trap low", int'(trap), 0);
        chk("R1 recover low", int'(rec), 0);
        for (int i = 0; i < NREGS; i++) look(i, 0, 0, "R1 reset entry");

        // R2: normal write
        drive(1, 3, 'h1234, 0, 0, 0, 3, 0, 0, 0, 0, 0); cycle();
        look(3, 'h1234, 0, "R2 stored");

        // R3: speculative fatal poisons
        drive(1, 5, 'hBEEF, 1, 2, 0, 0, 0, 0, 0, 0, 0); cycle();
        chk("R3 no trap", int'(trap), 0);
        look(5, 0, 1, "R3 poisoned");

        // R7: speculative read of poison is silent
        drive(0, 0, 0, 0, 0, 0, 5, 5, 3, 1, 0, 0); cycle();
        chk("R7 no fault", int'(uf), 0);

        // R6: non-speculative read on port 1
        drive(0, 0, 0, 0, 0, 0, 3, 5, 3, 0, 0, 0); cycle();
        chk("R6 fault on port1", int'(uf_port), 1);

        // R8: speculative write with poisoned source
        drive(1, 6, 'h5555, 1, 0, 1, 0, 0, 0, 0, 0, 0); cycle();
        look(6, 0, 1, "R8 propagated");

        // R11: both ports poisoned
        drive(0, 0, 0, 0, 0, 0, 6, 5, 3, 0, 0, 0); cycle();
        chk("R11 single fault port0", int'(uf_port), 0);
        chk("R11 single fault reg", int'(uf_reg), 6);

        // R12: check poisoned vs clean
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5); cycle();
        chk("R12 recover on poison", int'(rec), 1);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3); cycle();
        chk("R12 no recover on clean", int'(rec), 0);

        // R4: non-speculative fatal
        drive(1, 3, 'h9999, 0, 3, 0, 3, 0, 0, 0, 0, 0); cycle();
        look(3, 'h1234, 0, "R4 unchanged");

        // R5: resumable, speculative
        drive(1, 3, 'h7777, 1, 1, 0, 0, 0, 0, 0, 0, 0); cycle();
        chk("R5 resumable kind", int'(trap_fatal), 0);
        look(3, 'h1234, 0, "R5 unchanged");

        // R9: non-speculative with poisoned source is dropped
        drive(1, 3, 'h4444, 0, 0, 1, 0, 0, 0, 0, 0, 0); cycle();
        look(3, 'h1234, 0, "R9 unchanged");

        // R2: normal write clears poison; R13: same-cycle read sees old value
        drive(1, 5, 'h0A0A, 0, 0, 0, 5, 5, 0, 1, 0, 0); cycle();
        look(5, 'h0A0A, 0, "R2 poison cleared");

        // R10: register zero
        drive(1, 0, 'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0); cycle();
        drive(1, 0, 'hFFFF, 1, 2, 0, 0, 0, 0, 0, 0, 0); cycle();
        look(0, 0, 0, "R10 zero stays clean");

        // Random traffic against the model
        for (int n = 0; n < 500; n++) begin
            int x;
            int code;
            x = int'($urandom % 8);
            code = (x < 5) ? 0 : (x == 5) ? 1 : (x == 6) ? 2 : 3;
            drive($urandom % 3 != 0, int'($urandom % NREGS), int'($urandom), $urandom % 2 == 1,
                  code, $urandom % 4 == 0, int'($urandom % NREGS), int'($urandom % NREGS),
                  int'($urandom % 4), $urandom % 3 == 0, $urandom % 3 == 0,
                  int'($urandom % NREGS));
            cycle();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule